// File: doc/BRIEF.md
# Autoreload Down-Counting Interval Timer

This block is a memory-mapped interval timer with a 32-bit counter that steps downward from a programmed start value. Software reaches it through a small register bus with three word locations. The control word holds a clock-enable flag, a run flag, a reload-mode flag and a prescale field. The load word holds the value that is copied into the counter. The count word returns the live counter value. A reference tick enable from elsewhere in the chip feeds a power-of-two prescaler, and every prescaled tick moves the counter by one step.

A tick that arrives while the counter holds zero is an underflow. It raises a single-cycle interrupt pulse. In one-shot mode the hardware then clears the run flag, so the interrupt fires once per start. In periodic mode the counter takes the load value again and keeps counting, which gives one interrupt every load+1 ticks.

To start the timer, software first writes control with only clock enable set. It then writes the load value, and last writes control with clock enable, run and, if wanted, reload mode. If the load is all-ones and reload mode is on, the timer is a free-running 32-bit down-counter. Software bit-inverts the count to get an up-count.

Top module: `dntimer`

## Requirements
- R1: After reset, the control word and the count read back as zero, the stored load is zero, and `irq` and `bus_ready` are low.
- R2: A cycle with `bus_sel` high is answered by `bus_ready` high in exactly the next cycle, and read data is valid in that cycle. The control word at byte offset 0x0 reads back as follows: bit 0 is run, bit 1 is reload mode, bits 4:2 are the prescale field P, and bit 5 is clock enable. All higher bits read as zero, whatever was written to them.
- R3: A write to the load word at offset 0x4 is stored only while the clock-enable bit is already set. At any other time the write is ignored.
- R4: A control write that changes run from 0 to 1 copies the stored load value into the counter. The counter is read at offset 0x8.
- R5: The counter steps once every 2^(P+1) reference ticks, so P=0 divides by two. Cycles in which `ref_tick` is low do not advance the prescaler.
- R6: While run and clock enable are both set, each step lowers the count by one. A step taken at count zero is an underflow. It drives `irq` high for exactly one cycle, in the cycle right after the clock edge that takes the step. So the first interrupt comes (load+1)·2^(P+1) reference ticks after start.
- R7: In one-shot mode (reload bit 0), an underflow clears the run bit. The count then holds zero and no further interrupt occurs.
- R8: In periodic mode (reload bit 1), an underflow copies the stored load into the counter. Interrupts then repeat every (load+1)·2^(P+1) reference ticks.
- R9: Clearing the run bit stops counting at once, and the count holds its value.
- R10: A load written while the timer runs does not change the current count. It takes effect at the next reload.
- R11: Reads of the load offset and of unmapped offsets return zero. Writes to the count offset or to unmapped offsets change nothing.
- R12: With an all-ones load in periodic mode, the bit-inverted count rises by exactly one per step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | Reference tick enable that feeds the prescaler |
| bus_sel | input | 1 | Bus request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset (0x0 control, 0x4 load, 0x8 count) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Completion strobe, one cycle after the request |
| irq | output | 1 | Single-cycle underflow interrupt |

## Verification
The bench builds the block with a 32-bit counter and a 3-bit prescale field. The all-ones free-running case therefore uses the full counter width, and the prescale ratio covers everything from the minimum divide-by-two up to divide-by-256. Because the field is that narrow, even the largest divisor gives an interrupt interval of a few hundred cycles. The vector table can therefore measure the exact start-to-interrupt interval, and the second period in reload mode, for every mode and several load values, including a zero load. Directed cases cover a gapped reference tick, a stop part-way through a count, a reload value that changes while the timer runs, and the accesses that must be ignored.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
  localparam int PTV_W  = 3;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h8;

  // Control word, MSB first: clock enable, prescale, reload mode, run
  typedef struct packed {
    logic             clken;
    logic [PTV_W-1:0] ptv;
    logic             autorl;
    logic             start;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dntimer_regs.sv
module dntimer_regs
  import dntimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [DATA_W-1:0] cnt,
  input  logic              hw_stop,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] load_val,
  output logic              start_rise,
  output logic              ctrl_wr
);
  localparam int PAD_W = DATA_W - CTRL_W;

  ctrl_t             ctrl_q, ctrl_d, wr_val;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ready_q;
  logic              ld_wr, rd_en;

  // next-state logic
  always_comb begin
    ctrl_wr    = bus_sel & bus_we & (bus_addr == OFS_CTRL);
    ld_wr      = bus_sel & bus_we & (bus_addr == OFS_LOAD) & ctrl_q.clken;
    rd_en      = bus_sel & ~bus_we;
    wr_val     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    start_rise = ctrl_wr & wr_val.start & ~ctrl_q.start;

    ctrl_d = ctrl_q;
    if (hw_stop) ctrl_d.start = 1'b0;
    if (ctrl_wr) ctrl_d = wr_val;

    load_d = ld_wr ? bus_wdata : load_q;

    case (bus_addr)
      OFS_CTRL:  rdata_d = {{PAD_W{1'b0}}, ctrl_q};
      OFS_COUNT: rdata_d = cnt;
      default:   rdata_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      ready_q <= bus_sel;
      if (ld_wr) load_q  <= load_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign load_val  = load_q;
  assign bus_rdata = rdata_q;
  assign bus_ready = ready_q;
endmodule

// File: rtl/dntimer_prescale.sv
module dntimer_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ref_tick,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int DIV_W = 1 << PTV_W;

  logic [DIV_W-1:0] pcnt_q, pcnt_d, term;

  always_comb begin
    // terminal value 2^(ptv+1)-1
    term   = {DIV_W{1'b1}} >> (DIV_W - 1 - int'(ptv));
    tick   = run & ref_tick & (pcnt_q >= term);
    pcnt_d = pcnt_q;
    if (!run)          pcnt_d = '0;
    else if (ref_tick) pcnt_d = tick ? '0 : pcnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/dntimer_count.sv
module dntimer_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_rise,
  input  logic              autorl,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt,
  output logic              irq,
  output logic              hw_stop
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              irq_q, under;

  always_comb begin
    under   = tick & (cnt_q == '0);
    hw_stop = under & ~autorl;
    cnt_d   = cnt_q;
    if (start_rise)            cnt_d = load_val;
    else if (under && autorl)  cnt_d = load_val;
    else if (tick && !under)   cnt_d = cnt_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= under;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/dntimer.sv
module dntimer
  import dntimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              irq
);
  logic              rst_meta, rst_sync_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] load_val, cnt;
  logic              start_rise, ctrl_wr, hw_stop, tick, run, autorl_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign run       = ctrl.start & ctrl.clken;
  assign autorl_en = ctrl.autorl;

  dntimer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .cnt        (cnt),
    .hw_stop    (hw_stop),
    .ctrl       (ctrl),
    .load_val   (load_val),
    .start_rise (start_rise),
    .ctrl_wr    (ctrl_wr)
  );

  dntimer_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .ref_tick (ref_tick),
    .ptv      (ctrl.ptv),
    .tick     (tick)
  );

  dntimer_count #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .start_rise (start_rise),
    .autorl     (autorl_en),
    .load_val   (load_val),
    .cnt        (cnt),
    .irq        (irq),
    .hw_stop    (hw_stop)
  );
endmodule

// File: rtl/dntimer_chk.sv
module dntimer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic              start_rise,
  input logic              ctrl_wr,
  input logic              autorl,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] load_val,
  input logic              irq,
  input logic              bus_sel,
  input logic              bus_ready
);
  // R2
  p_ready_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  p_no_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);
  // R4
  p_start_copies_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> (cnt == $past(load_val)));
  // R6
  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> (cnt == $past(cnt) - DATA_W'(1)));
  p_underflow_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> irq);
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  p_oneshot_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && !autorl && !ctrl_wr) |=> !run);
  // R8
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && autorl) |=> (cnt == $past(load_val)));
  // R9
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_rise) |=> $stable(cnt));
endmodule

bind dntimer dntimer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick),
  .run        (run),
  .start_rise (start_rise),
  .ctrl_wr    (ctrl_wr),
  .autorl     (autorl_en),
  .cnt        (cnt),
  .load_val   (load_val),
  .irq        (irq),
  .bus_sel    (bus_sel),
  .bus_ready  (bus_ready)
);

// File: tb/sim_dntimer.sv
module sim_dntimer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] C_CLKEN = 32'h20;
  localparam logic [31:0] C_START = 32'h01;
  localparam logic [31:0] C_AR    = 32'h02;
  localparam int          NVEC    = 8;
  // {load, prescale field, reload mode}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'd3,  8'd0, 8'd0},
    {32'd0,  8'd0, 8'd0},
    {32'd5,  8'd1, 8'd0},
    {32'd2,  8'd2, 8'd1},
    {32'd0,  8'd0, 8'd1},
    {32'd1,  8'd7, 8'd0},
    {32'd10, 8'd3, 8'd1},
    {32'd6,  8'd1, 8'd1}
  };

  logic        clk, rst_n, ref_tick;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  dntimer u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    chk("R2 ready", {31'd0, bus_ready}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int limit, inout int k);
    while (!irq && k < limit) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
  endtask

  task automatic run_vec(input int i);
    logic [31:0] ld, rv;
    int ptv, ar, per, k, quiet;
    ld  = VEC[i][47:16];
    ptv = int'(VEC[i][15:8]);
    ar  = int'(VEC[i][7:0]);
    per = (int'(ld) + 1) << (ptv + 1);
    wr(4'h0, C_CLKEN);
    wr(4'h4, ld);
    wr(4'h0, C_CLKEN | C_START | (32'(ptv) << 2) | (ar != 0 ? C_AR : 32'd0));
    k = 0;
    wait_irq(per + 50, k);
    chk("R6 first interval", 32'(k), 32'(per));
    @(posedge clk); @(negedge clk);
    chk("R6 pulse width", {31'd0, irq}, 32'd0);
    if (ar != 0) begin
      k = 1;
      wait_irq(per + 50, k);
      chk("R8 period", 32'(k), 32'(per));
      wr(4'h0, C_CLKEN);
    end else begin
      quiet = 0;
      repeat (2 * per + 4) begin
        @(posedge clk); @(negedge clk);
        if (irq) quiet++;
      end
      chk("R7 no second irq", 32'(quiet), 32'd0);
      rd(4'h0, rv);
      chk("R7 run cleared", rv, C_CLKEN | (32'(ptv) << 2));
      rd(4'h8, rv);
      chk("R7 count holds zero", rv, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] v, v2;
    int k, rc, ph;
    rst_n = 0; ref_tick = 1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 ready", {31'd0, bus_ready}, 32'd0);
    rd(4'h0, v); chk("R1 control", v, 32'd0);
    rd(4'h8, v); chk("R1 count", v, 32'd0);
    // R11 load offset reads zero
    rd(4'h4, v); chk("R11 load reads zero", v, 32'd0);

    // R3 load gated by clock enable, R4 copy on start
    wr(4'h0, C_CLKEN);
    wr(4'h4, 32'd9);
    wr(4'h0, 32'd0);
    wr(4'h4, 32'd7);
    wr(4'h0, C_CLKEN);
    wr(4'h0, C_CLKEN | C_START | (32'd7 << 2));
    rd(4'h8, v); chk("R3 R4 count after start", v, 32'd9);
    rd(4'h0, v); chk("R2 control layout", v, 32'h3D);
    // R11 writes to count and unmapped offsets ignored
    wr(4'h8, 32'h1234);
    wr(4'hC, 32'h5678);
    rd(4'h8, v); chk("R11 count write ignored", v, 32'd9);
    rd(4'hC, v); chk("R11 unmapped reads zero", v, 32'd0);
    wr(4'h0, 32'hFFFF_FF20);
    rd(4'h0, v); chk("R2 upper bits zero", v, C_CLKEN);

    // table of modes
    for (int i = 0; i < NVEC; i++) run_vec(i);

    // R9 stop holds count
    wr(4'h4, 32'd100);
    wr(4'h0, C_CLKEN | C_START);
    repeat (20) @(negedge clk);
    wr(4'h0, C_CLKEN);
    rd(4'h8, v); chk("R9 count at stop", v, 32'd90);
    repeat (30) @(negedge clk);
    rd(4'h8, v2); chk("R9 count holds", v2, v);

    // R10 load change while running
    wr(4'h4, 32'd3);
    wr(4'h0, C_CLKEN | C_START | C_AR);
    wr(4'h4, 32'd1);
    k = 1;
    wait_irq(100, k);
    chk("R10 current period unchanged", 32'(k), 32'd8);
    @(posedge clk); @(negedge clk);
    k = 1;
    wait_irq(100, k);
    chk("R10 new period after reload", 32'(k), 32'd4);
    wr(4'h0, C_CLKEN);

    // R12 free-running all-ones
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, C_CLKEN | C_START | C_AR);
    rd(4'h8, v);
    repeat (19) @(negedge clk);
    rd(4'h8, v2);
    chk("R12 near top", {31'd0, (~v < 32'd4)}, 32'd1);
    chk("R12 up-count step", (~v2) - (~v), 32'd10);
    wr(4'h0, C_CLKEN);

    // R5 gapped reference tick, P=1, load 2, one-shot
    ref_tick = 0;
    wr(4'h4, 32'd2);
    wr(4'h0, C_CLKEN | C_START | (32'd1 << 2));
    rc = 0; ph = 0;
    for (int n = 0; n < 200 && !irq; n++) begin
      ref_tick = (ph == 0);
      ph = (ph + 1) % 3;
      @(posedge clk);
      if (ref_tick) rc++;
      @(negedge clk);
    end
    chk("R5 reference ticks to irq", 32'(rc), 32'd12);
    ref_tick = 1;

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule